// File: doc/BRIEF.md
# Decrement-and-Branch Loop Unit

This unit resolves a count-down loop instruction in the execute stage of a 32-bit pipeline. Each instruction carries its own PC, the index and current value of one source register, and a 16-bit immediate branch offset. If the register holds a signed value above zero, the unit asks for that register to be written with its value minus one and redirects the PC backwards or forwards by the offset. Otherwise it reports a fall-through to the next sequential instruction and leaves the register alone.

Instructions enter on a valid/ready stream and results leave on a second valid/ready stream through one register stage. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the result stays put and the unit accepts nothing new. The redirect flag, the write enable and the new register value always leave in the same beat, so downstream logic sees the branch and the register update together.

Top module: `loopbr_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low) and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted instruction whose register value is greater than zero as a signed 32-bit number produces `out_taken`=1 and `out_next_pc` = PC + 4 + (immediate sign-extended to 32 bits and shifted left by 2).
- R3: For such an instruction with a nonzero register index, `out_wb_en`=1, `out_wb_idx` equals the index and `out_wb_data` equals the register value minus 1.
- R4: An accepted instruction whose register value is zero produces `out_taken`=0, `out_wb_en`=0, `out_next_pc` = PC + 4 and `out_wb_data` equal to the unchanged register value.
- R5: A register value with bit 31 set counts as negative and falls through exactly as in R4, even for 0x80000000.
- R6: Register index 0 never gets `out_wb_en`=1, even when the branch is taken. The redirect of R2 still happens.
- R7: `out_wb_en`=1 only ever appears in a beat where `out_taken`=1.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid`=1 and `out_ready`=0, every output field holds its value on the next cycle.
- R9: Every accepted instruction yields exactly one result, and results leave in acceptance order.
- R10: PC arithmetic is modulo 2^32. A negative immediate (bit 15 set) moves the target below PC + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| in_pc | input | 32 | PC of the loop instruction |
| in_rs_idx | input | 5 | Index of the counted register |
| in_rs_val | input | 32 | Current value of the counted register |
| in_imm | input | 16 | Raw branch offset in words |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_next_pc | output | 32 | PC to fetch next |
| out_taken | output | 1 | Branch redirects the PC |
| out_wb_en | output | 1 | Register write requested |
| out_wb_idx | output | 5 | Register to write |
| out_wb_data | output | 32 | Value for the register |

## Verification
The properties assume the producer keeps its instruction fields stable while it waits with `in_valid` high and `in_ready` low. They also assume that reset is released only on a clock edge. The bench keeps within these assumptions because it changes inputs only on the falling edge, holds an instruction until the cycle in which `in_ready` is seen high, and toggles `out_ready` freely so that both stall and streaming phases occur. The stimulus covers the sign boundary values 0, 1, -1, 0x7FFFFFFF and 0x80000000, register index 0, both extreme immediates, and a PC near the top of the address space.

// File: rtl/loopbr_pkg.sv
package loopbr_pkg;
  localparam int unsigned XLEN_DEF      = 32;
  localparam int unsigned IMM_W_DEF     = 16;
  localparam int unsigned IDX_W_DEF     = 5;
  localparam int unsigned INSN_BYTES    = 4;
  localparam int unsigned OFFSET_SHIFT  = 2;

  typedef enum logic {
    OUTCOME_FALL = 1'b0,
    OUTCOME_LOOP = 1'b1
  } loop_outcome_e;
endpackage

// File: rtl/loopbr_cond.sv
module loopbr_cond #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IDX_W      = 5,
  parameter bit          GUARD_ZERO = 1'b1
) (
  input  logic [XLEN-1:0]          rs_val,
  input  logic [IDX_W-1:0]         rs_idx,
  output loopbr_pkg::loop_outcome_e outcome,
  output logic                     wb_en,
  output logic [XLEN-1:0]          wb_data
);
  logic positive;

  // signed value above zero: sign bit clear and some bit set
  assign positive = ~rs_val[XLEN-1] & (|rs_val[XLEN-2:0]);
  assign outcome  = positive ? loopbr_pkg::OUTCOME_LOOP : loopbr_pkg::OUTCOME_FALL;
  assign wb_data  = positive ? (rs_val - XLEN'(1)) : rs_val;

  generate
    if (GUARD_ZERO) begin : g_guard
      assign wb_en = positive & (|rs_idx);
    end else begin : g_noguard
      logic unused_idx;
      assign unused_idx = ^rs_idx;
      assign wb_en = positive & ~(unused_idx & 1'b0);
    end
  endgenerate
endmodule

// File: rtl/loopbr_target.sv
module loopbr_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned SHIFT = 2,
  parameter int unsigned STEP  = 4
) (
  input  logic [XLEN-1:0]           pc,
  input  logic [IMM_W-1:0]          imm,
  input  loopbr_pkg::loop_outcome_e outcome,
  output logic [XLEN-1:0]           next_pc
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] ext_imm;
  logic [XLEN-1:0] byte_ofs;

  assign seq_pc   = pc + XLEN'(STEP);
  assign ext_imm  = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign byte_ofs = ext_imm << SHIFT;
  assign next_pc  = (outcome == loopbr_pkg::OUTCOME_LOOP) ? (seq_pc + byte_ofs) : seq_pc;
endmodule

// File: rtl/loopbr_stage.sv
module loopbr_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign s_ready = ~full_q | m_ready;
  assign m_valid = full_q;
  assign m_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (s_ready) begin
      full_q <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) begin
      data_q <= s_data;
    end
  end
endmodule

// File: rtl/loopbr_unit.sv
module loopbr_unit #(
  parameter int unsigned XLEN       = loopbr_pkg::XLEN_DEF,
  parameter int unsigned IMM_W      = loopbr_pkg::IMM_W_DEF,
  parameter int unsigned IDX_W      = loopbr_pkg::IDX_W_DEF,
  parameter bit          GUARD_ZERO = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  in_pc,
  input  logic [IDX_W-1:0] in_rs_idx,
  input  logic [XLEN-1:0]  in_rs_val,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_next_pc,
  output logic             out_taken,
  output logic             out_wb_en,
  output logic [IDX_W-1:0] out_wb_idx,
  output logic [XLEN-1:0]  out_wb_data
);
  localparam int unsigned DATA_W = 2 * XLEN + 2 + IDX_W;

  loopbr_pkg::loop_outcome_e outcome;
  logic                      wb_en_c;
  logic [XLEN-1:0]           wb_data_c;
  logic [XLEN-1:0]           next_pc_c;
  logic [DATA_W-1:0]         pack_in;
  logic [DATA_W-1:0]         pack_out;

  loopbr_cond #(
    .XLEN(XLEN), .IDX_W(IDX_W), .GUARD_ZERO(GUARD_ZERO)
  ) cond_i (
    .rs_val (in_rs_val),
    .rs_idx (in_rs_idx),
    .outcome(outcome),
    .wb_en  (wb_en_c),
    .wb_data(wb_data_c)
  );

  loopbr_target #(
    .XLEN(XLEN), .IMM_W(IMM_W),
    .SHIFT(loopbr_pkg::OFFSET_SHIFT), .STEP(loopbr_pkg::INSN_BYTES)
  ) target_i (
    .pc     (in_pc),
    .imm    (in_imm),
    .outcome(outcome),
    .next_pc(next_pc_c)
  );

  // redirect and write-back travel in one word so they leave in one beat
  assign pack_in = {next_pc_c, (outcome == loopbr_pkg::OUTCOME_LOOP), wb_en_c, in_rs_idx, wb_data_c};

  loopbr_stage #(.W(DATA_W)) stage_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (pack_in),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (pack_out)
  );

  assign {out_next_pc, out_taken, out_wb_en, out_wb_idx, out_wb_data} = pack_out;
endmodule

// File: rtl/loopbr_unit_chk.sv
module loopbr_unit_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [XLEN-1:0]  in_pc,
  input logic [IDX_W-1:0] in_rs_idx,
  input logic [XLEN-1:0]  in_rs_val,
  input logic [IMM_W-1:0] in_imm,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  out_next_pc,
  input logic             out_taken,
  input logic             out_wb_en,
  input logic [IDX_W-1:0] out_wb_idx,
  input logic [XLEN-1:0]  out_wb_data
);
  function automatic logic [XLEN-1:0] ofs(input logic [IMM_W-1:0] i);
    logic [XLEN-1:0] e;
    e = {{(XLEN-IMM_W){i[IMM_W-1]}}, i};
    return e << 2;
  endfunction

  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && $signed(in_rs_val) > 0) |=> (out_valid && out_taken &&
      out_next_pc == $past(in_pc) + 32'd4 + ofs($past(in_imm))));

  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && $signed(in_rs_val) > 0) |=> (out_wb_data == $past(in_rs_val) - 32'd1));

  // R4
  zero_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_rs_val == '0) |=> (out_valid && !out_taken && !out_wb_en &&
      out_next_pc == $past(in_pc) + 32'd4));

  // R5
  negative_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_rs_val[XLEN-1]) |=> (!out_taken && !out_wb_en &&
      out_wb_data == $past(in_rs_val) && out_next_pc == $past(in_pc) + 32'd4));

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_rs_idx == '0) |=> !out_wb_en);

  // R7
  same_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wb_en) |-> out_taken);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc) && $stable(out_taken) &&
      $stable(out_wb_en) && $stable(out_wb_idx) && $stable(out_wb_data)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind loopbr_unit loopbr_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/loopbr_unit_tb_top.sv
`timescale 1ns/100ps
module loopbr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [4:0]  in_rs_idx = '0;
  logic [31:0] in_rs_val = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_next_pc;
  logic        out_taken;
  logic        out_wb_en;
  logic [4:0]  out_wb_idx;
  logic [31:0] out_wb_data;

  always #2.5 clk = ~clk;

  loopbr_unit dut_i (.*);

  typedef struct packed {
    logic [31:0] next_pc;
    logic        taken;
    logic        wb_en;
    logic [4:0]  idx;
    logic [31:0] data;
    logic [31:0] rs;
    logic [15:0] imm;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;
  bit prev_stall = 1'b0;
  logic [70:0] prev_out;

  function automatic exp_t model(logic [31:0] pc, logic [4:0] idx, logic [31:0] rs, logic [15:0] imm);
    exp_t e;
    int signed off;
    off = int'($signed(imm)) * 4;
    e.taken   = $signed(rs) > 0;
    e.next_pc = e.taken ? pc + 32'd4 + 32'(off) : pc + 32'd4;
    e.wb_en   = e.taken && idx != 0;
    e.idx     = idx;
    e.data    = e.taken ? rs - 32'd1 : rs;
    e.rs      = rs;
    e.imm     = imm;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string pc_tag(exp_t e);
    if (e.imm[15] && e.taken) return "R10";
    if (e.taken) return "R2";
    if (e.rs == 0) return "R4";
    return "R5";
  endfunction

  task automatic observe();
    // R8 ready rule
    chk(in_ready == (!out_valid || out_ready), "R8", "in_ready", in_ready, !out_valid || out_ready);
    if (prev_stall)
      chk({out_next_pc, out_taken, out_wb_en, out_wb_idx, out_wb_data} == prev_out, "R8", "held result",
          out_wb_data, prev_out[31:0]);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected result", out_next_pc, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_next_pc == e.next_pc, pc_tag(e), "next_pc", out_next_pc, e.next_pc);
        chk(out_taken == e.taken, e.taken ? "R2" : (e.rs == 0 ? "R4" : "R5"), "taken", 32'(out_taken), 32'(e.taken));
        chk(out_wb_en == e.wb_en, (e.idx == 0) ? "R6" : "R3", "wb_en", 32'(out_wb_en), 32'(e.wb_en));
        chk(!out_wb_en || out_taken, "R7", "wb_en without taken", 32'(out_wb_en), 32'(out_taken));
        chk(out_wb_idx == e.idx, "R3", "wb_idx", 32'(out_wb_idx), 32'(e.idx));
        chk(out_wb_data == e.data, e.taken ? "R3" : "R4", "wb_data", out_wb_data, e.data);
      end
    end
    if (in_valid && in_ready) exp_q.push_back(model(in_pc, in_rs_idx, in_rs_val, in_imm));
    prev_stall = out_valid && !out_ready;
    prev_out   = {out_next_pc, out_taken, out_wb_en, out_wb_idx, out_wb_data};
  endtask

  function automatic bit pick_ready();
    if (rdy_mode == 0) return 1'b1;
    if (rdy_mode == 1) return ($urandom % 3) != 0;
    return ($urandom % 4) == 0;
  endfunction

  task automatic send(input logic [31:0] pc, input logic [4:0] idx, input logic [31:0] rs, input logic [15:0] imm);
    bit first = 1'b1;
    forever begin
      @(negedge clk);
      if (first) begin
        in_valid = 1'b1; in_pc = pc; in_rs_idx = idx; in_rs_val = rs; in_imm = imm;
        first = 1'b0;
      end
      out_ready = pick_ready();
      #1;
      begin
        bit acc;
        acc = in_ready;
        observe();
        if (acc) break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = pick_ready();
      #1;
      observe();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "state after reset", {30'd0, out_valid, in_ready}, 32'd1);

    // directed boundary patterns, streaming
    send(32'h0000_1000, 5'd8,  32'd1,          16'hFFFE); // R2 last pass, R10 backward
    send(32'h0000_1000, 5'd8,  32'd0,          16'hFFFE); // R4
    send(32'h0000_2000, 5'd9,  32'hFFFF_FFFF,  16'h0010); // R5
    send(32'h0000_2000, 5'd9,  32'h8000_0000,  16'h0010); // R5
    send(32'h0000_3000, 5'd31, 32'h7FFF_FFFF,  16'h7FFF); // R2 R3
    send(32'h0000_3000, 5'd0,  32'd5,          16'h0004); // R6
    send(32'h0000_3000, 5'd0,  32'd0,          16'h0004); // R6 R4
    send(32'hFFFF_FFFC, 5'd3,  32'd2,          16'h0001); // R10 wrap
    send(32'h0000_0004, 5'd3,  32'd2,          16'h8000); // R10 wrap below zero
    send(32'hFFFF_FFFC, 5'd3,  32'd0,          16'h0001); // R4 wrap
    idle(3);

    // count-down loop under back-pressure
    rdy_mode = 1;
    for (int c = 4; c >= -1; c--) send(32'h0000_4010, 5'd12, 32'(c), 16'hFFFC);
    idle(4);

    // random mix, heavy stalls then light
    for (int ph = 2; ph >= 1; ph--) begin
      rdy_mode = ph;
      for (int n = 0; n < 300; n++) begin
        logic [31:0] v;
        case ($urandom % 4)
          0: v = $urandom % 4;
          1: v = 32'hFFFF_FFFF - ($urandom % 3);
          2: v = 32'h8000_0000 + ($urandom % 2);
          default: v = $urandom;
        endcase
        send({$urandom} & 32'hFFFF_FFFC, 5'($urandom), v, 16'($urandom));
        if (($urandom % 5) == 0) idle(1 + $urandom % 3);
      end
    end

    // drain and confirm one result per instruction
    rdy_mode = 0;
    idle(4);
    chk(exp_q.size() == 0, "R9", "results missing", 32'(exp_q.size()), 32'd0);
    chk(out_valid == 1'b0, "R9", "extra result pending", 32'(out_valid), 32'd0);
    finish_run();
  end
endmodule